// File: doc/BRIEF.md
# Receive Descriptor Buffer Sequencer

This block steps through a receive DMA descriptor list and decides which data buffers a data mover fills and where the next descriptor is read from. When a descriptor arrives (a 32-bit control word, a first buffer pointer and a second pointer), the block issues up to two buffer requests in turn. Each request carries an address and a byte length. A request stays up until the mover reports it done. The mover also says whether the received frame ended in that buffer. When the descriptor is used up, the block works out the next descriptor address and raises a fetch request for it.

The list can take two forms. In ring form, descriptors sit one after another in memory, with an optional gap between them. In chained form, the second pointer of each descriptor names the next descriptor. An end-of-ring flag sends the walk back to the list base address, and it takes priority over chaining. Buffers of zero length are skipped. A per-descriptor quiet flag masks the frame-complete event. A buffer length that is not a whole number of bus words is reported on an error pulse.

The state machine has five states:
- `ST_IDLE` waits for start.
- `ST_FETCH` requests a descriptor.
- `ST_BUF1` serves the first buffer.
- `ST_BUF2` serves the second buffer.
- `ST_NEXT` computes the next descriptor address for one cycle.

It has these transitions:
- IDLE→FETCH on start.
- FETCH→BUF1 when a descriptor arrives with a non-zero first length.
- FETCH→BUF2 when the first length is zero and the second buffer is in use.
- FETCH→NEXT when neither buffer is in use.
- BUF1→BUF2 when the first buffer completes without frame end and the second buffer is in use.
- BUF1→NEXT when the first buffer completes with frame end, or when the second buffer is not in use.
- BUF2→NEXT when the second buffer completes.
- NEXT→FETCH always.

Top module: `rxdesc_seq`

## Requirements
- R1: After reset the block is idle and issues no descriptor or buffer request. A `start_i` pulse in idle makes the first descriptor fetch use `list_base_i`.
- R2: Control word fields are decoded as follows:
  - bits 12:0 give the first buffer length.
  - bits 28:16 give the second buffer length.
  - bit 14 is the chained flag.
  - bit 15 is the end-of-ring flag.
  - bit 31 is the quiet flag.
  Bits 13, 29 and 30 have no effect on any output.
- R3: When the first length is non-zero, a buffer request goes out with the first pointer as address and the first length as length. When the first length is zero, no request for it is made.
- R4: When the chained flag is clear and the second length is non-zero, a request goes out with the second pointer and the second length, after any first-buffer request. Otherwise no second request is made.
- R5: If the frame ends in the first buffer, the second buffer is not requested.
- R6: The next descriptor address is chosen as follows:
  - the list base when end-of-ring is set, whether or not chained is set;
  - otherwise the second pointer when chained is set;
  - otherwise the current address plus 16 plus 4 times `skip_words_i`, with `skip_words_i` sampled once the descriptor's last buffer is done.
- R7: `frame_done_o` is high in exactly the cycle in which a buffer request is completed with `frame_end_i` high, unless the quiet flag is set.
- R8: `size_err_o` pulses in the cycle a descriptor is accepted when the first length, or the second length of a buffer in use, is not a multiple of 4.
- R9: The two request outputs are never high together. A request holds its address and length until its handshake.
- R10: A `start_i` pulse while the block is not idle has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin walking the list from its base (idle only) |
| list_base_i | input | AW | Address of the first descriptor of the list |
| skip_words_i | input | SKIP_W | Gap between ring descriptors, in 32-bit words |
| desc_req_o | output | 1 | Descriptor fetch request |
| desc_addr_o | output | AW | Address of the descriptor to fetch |
| desc_valid_i | input | 1 | Fetched descriptor present on the inputs below |
| desc_ctrl_i | input | 32 | Descriptor control word |
| desc_ptr1_i | input | AW | First buffer pointer |
| desc_ptr2_i | input | AW | Second buffer pointer or next descriptor address |
| buf_req_o | output | 1 | Buffer fill request |
| buf_addr_o | output | AW | Buffer start address |
| buf_len_o | output | 13 | Buffer length in bytes |
| buf_done_i | input | 1 | Current buffer finished |
| frame_end_i | input | 1 | Frame ended in the current buffer (with `buf_done_i`) |
| frame_done_o | output | 1 | Frame-complete event |
| size_err_o | output | 1 | Misaligned buffer length seen at descriptor accept |

## Verification
The bench uses the default widths: 32-bit addresses, a 5-bit skip field and 4-byte bus words. It sweeps 288 consecutive descriptors on a single walk. The sweep covers every combination of:
- four first lengths: zero, 8, the largest aligned value 8188, and a misaligned 6;
- three second lengths: zero, aligned 20, misaligned 18;
- the chained and end-of-ring flags;
- the quiet flag;
- three frame-end placements: none, first served buffer, last served buffer.

The skip value rotates through 0 to 3 and the reserved bits toggle, so every next-address rule and skip path is reached. Start pulses during buffer service test that a busy block ignores them.

// File: rtl/rxdesc_pkg.sv
package rxdesc_pkg;

    localparam int CTRL_W     = 32;
    localparam int SIZE_W     = 13;
    localparam int LEN1_LSB   = 0;
    localparam int LEN2_LSB   = 16;
    localparam int CHAIN_BIT  = 14;
    localparam int RING_BIT   = 15;
    localparam int QUIET_BIT  = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_BUF1,
        ST_BUF2,
        ST_NEXT
    } seq_state_t;

    typedef struct packed {
        logic              quiet;
        logic              ring_end;
        logic              chained;
        logic [SIZE_W-1:0] len1;
        logic [SIZE_W-1:0] len2;
    } desc_ctl_t;

endpackage

// File: rtl/rxdesc_decode.sv
module rxdesc_decode
    import rxdesc_pkg::*;
#(
    parameter int BUS_BYTES = 4
) (
    input  logic [CTRL_W-1:0] ctrl_i,
    output desc_ctl_t         ctl_o,
    output logic              use_b2_o,
    output logic              misalign_o
);

    logic unused_rsvd;
    logic odd1;
    logic odd2;

    assign unused_rsvd = ^{ctrl_i[30:29], ctrl_i[13]};

    always_comb begin
        ctl_o.quiet    = ctrl_i[QUIET_BIT];
        ctl_o.ring_end = ctrl_i[RING_BIT];
        ctl_o.chained  = ctrl_i[CHAIN_BIT];
        ctl_o.len1     = ctrl_i[LEN1_LSB +: SIZE_W];
        ctl_o.len2     = ctrl_i[LEN2_LSB +: SIZE_W];
    end

    assign use_b2_o   = !ctl_o.chained && (ctl_o.len2 != '0);
    assign odd1       = (32'(ctl_o.len1) % BUS_BYTES) != 0;
    assign odd2       = (32'(ctl_o.len2) % BUS_BYTES) != 0;
    assign misalign_o = odd1 || (use_b2_o && odd2);

endmodule

// File: rtl/rxdesc_nextaddr.sv
module rxdesc_nextaddr #(
    parameter int AW         = 32,
    parameter int SKIP_W     = 5,
    parameter int DESC_BYTES = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic [AW-1:0]     cur_i,
    input  logic [AW-1:0]     base_i,
    input  logic [AW-1:0]     link_i,
    input  logic              ring_end_i,
    input  logic              chained_i,
    input  logic [SKIP_W-1:0] skip_i,
    output logic [AW-1:0]     next_o
);

    localparam int          WORD_SH = $clog2(WORD_BYTES);
    localparam logic [AW-1:0] STRIDE = AW'(DESC_BYTES);

    logic [AW-1:0] gap;
    logic [AW-1:0] seq_addr;

    assign gap      = {{(AW-SKIP_W){1'b0}}, skip_i} << WORD_SH;
    assign seq_addr = cur_i + STRIDE + gap;

    // end of ring outranks the chain link
    always_comb begin
        if (ring_end_i)
            next_o = base_i;
        else if (chained_i)
            next_o = link_i;
        else
            next_o = seq_addr;
    end

endmodule

// File: rtl/rxdesc_fsm.sv
module rxdesc_fsm
    import rxdesc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [AW-1:0]     list_base_i,
    input  logic              desc_valid_i,
    input  desc_ctl_t         dec_ctl_i,
    input  logic              dec_use_b2_i,
    input  logic              dec_misalign_i,
    input  logic [AW-1:0]     ptr1_i,
    input  logic [AW-1:0]     ptr2_i,
    input  logic              buf_done_i,
    input  logic              frame_end_i,
    input  logic [AW-1:0]     next_addr_i,
    output logic [AW-1:0]     cur_addr_o,
    output logic              lat_ring_end_o,
    output logic              lat_chained_o,
    output logic [AW-1:0]     lat_ptr2_o,
    output logic              desc_req_o,
    output logic              buf_req_o,
    output logic [AW-1:0]     buf_addr_o,
    output logic [SIZE_W-1:0] buf_len_o,
    output logic              frame_done_o,
    output logic              size_err_o
);

    seq_state_t state_q;
    seq_state_t state_d;
    desc_ctl_t  ctl_q;
    logic       use_b2_q;
    logic [AW-1:0] ptr1_q;
    logic [AW-1:0] ptr2_q;
    logic [AW-1:0] cur_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // descriptor and address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            use_b2_q <= 1'b0;
            ptr1_q   <= '0;
            ptr2_q   <= '0;
            cur_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i)
                        cur_q <= list_base_i;
                end
                ST_FETCH: begin
                    if (desc_valid_i) begin
                        ctl_q    <= dec_ctl_i;
                        use_b2_q <= dec_use_b2_i;
                        ptr1_q   <= ptr1_i;
                        ptr2_q   <= ptr2_i;
                    end
                end
                ST_NEXT: cur_q <= next_addr_i;
                default: ;
            endcase
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i)
                    state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (desc_valid_i) begin
                    if (dec_ctl_i.len1 != '0)
                        state_d = ST_BUF1;
                    else if (dec_use_b2_i)
                        state_d = ST_BUF2;
                    else
                        state_d = ST_NEXT;
                end
            end
            ST_BUF1: begin
                if (buf_done_i) begin
                    if (!frame_end_i && use_b2_q)
                        state_d = ST_BUF2;
                    else
                        state_d = ST_NEXT;
                end
            end
            ST_BUF2: begin
                if (buf_done_i)
                    state_d = ST_NEXT;
            end
            ST_NEXT: state_d = ST_FETCH;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        desc_req_o   = 1'b0;
        buf_req_o    = 1'b0;
        buf_addr_o   = '0;
        buf_len_o    = '0;
        frame_done_o = 1'b0;
        size_err_o   = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                desc_req_o = 1'b1;
                size_err_o = desc_valid_i && dec_misalign_i;
            end
            ST_BUF1: begin
                buf_req_o    = 1'b1;
                buf_addr_o   = ptr1_q;
                buf_len_o    = ctl_q.len1;
                frame_done_o = buf_done_i && frame_end_i && !ctl_q.quiet;
            end
            ST_BUF2: begin
                buf_req_o    = 1'b1;
                buf_addr_o   = ptr2_q;
                buf_len_o    = ctl_q.len2;
                frame_done_o = buf_done_i && frame_end_i && !ctl_q.quiet;
            end
            default: ;
        endcase
    end

    assign cur_addr_o     = cur_q;
    assign lat_ring_end_o = ctl_q.ring_end;
    assign lat_chained_o  = ctl_q.chained;
    assign lat_ptr2_o     = ptr2_q;

endmodule

// File: rtl/rxdesc_seq.sv
module rxdesc_seq
    import rxdesc_pkg::*;
#(
    parameter int AW         = 32,
    parameter int SKIP_W     = 5,
    parameter int DESC_BYTES = 16,
    parameter int BUS_BYTES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [AW-1:0]     list_base_i,
    input  logic [SKIP_W-1:0] skip_words_i,
    output logic              desc_req_o,
    output logic [AW-1:0]     desc_addr_o,
    input  logic              desc_valid_i,
    input  logic [31:0]       desc_ctrl_i,
    input  logic [AW-1:0]     desc_ptr1_i,
    input  logic [AW-1:0]     desc_ptr2_i,
    output logic              buf_req_o,
    output logic [AW-1:0]     buf_addr_o,
    output logic [12:0]       buf_len_o,
    input  logic              buf_done_i,
    input  logic              frame_end_i,
    output logic              frame_done_o,
    output logic              size_err_o
);

    desc_ctl_t     dec_ctl;
    logic          dec_use_b2;
    logic          dec_misalign;
    logic [AW-1:0] cur_addr;
    logic [AW-1:0] next_addr;
    logic          lat_ring_end;
    logic          lat_chained;
    logic [AW-1:0] lat_ptr2;

    rxdesc_decode #(
        .BUS_BYTES (BUS_BYTES)
    ) u_decode (
        .ctrl_i     (desc_ctrl_i),
        .ctl_o      (dec_ctl),
        .use_b2_o   (dec_use_b2),
        .misalign_o (dec_misalign)
    );

    rxdesc_nextaddr #(
        .AW         (AW),
        .SKIP_W     (SKIP_W),
        .DESC_BYTES (DESC_BYTES),
        .WORD_BYTES (BUS_BYTES)
    ) u_nextaddr (
        .cur_i      (cur_addr),
        .base_i     (list_base_i),
        .link_i     (lat_ptr2),
        .ring_end_i (lat_ring_end),
        .chained_i  (lat_chained),
        .skip_i     (skip_words_i),
        .next_o     (next_addr)
    );

    rxdesc_fsm #(
        .AW (AW)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .list_base_i    (list_base_i),
        .desc_valid_i   (desc_valid_i),
        .dec_ctl_i      (dec_ctl),
        .dec_use_b2_i   (dec_use_b2),
        .dec_misalign_i (dec_misalign),
        .ptr1_i         (desc_ptr1_i),
        .ptr2_i         (desc_ptr2_i),
        .buf_done_i     (buf_done_i),
        .frame_end_i    (frame_end_i),
        .next_addr_i    (next_addr),
        .cur_addr_o     (cur_addr),
        .lat_ring_end_o (lat_ring_end),
        .lat_chained_o  (lat_chained),
        .lat_ptr2_o     (lat_ptr2),
        .desc_req_o     (desc_req_o),
        .buf_req_o      (buf_req_o),
        .buf_addr_o     (buf_addr_o),
        .buf_len_o      (buf_len_o),
        .frame_done_o   (frame_done_o),
        .size_err_o     (size_err_o)
    );

    assign desc_addr_o = cur_addr;

endmodule

// File: rtl/rxdesc_seq_chk.sv
module rxdesc_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          desc_req_o,
    input logic [AW-1:0] desc_addr_o,
    input logic          desc_valid_i,
    input logic          buf_req_o,
    input logic [AW-1:0] buf_addr_o,
    input logic [12:0]   buf_len_o,
    input logic          buf_done_i,
    input logic          frame_end_i,
    input logic          frame_done_o,
    input logic          size_err_o
);

    // R9
    no_dual_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_req_o && buf_req_o));

    // R9
    desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_req_o && !desc_valid_i |=> desc_req_o && $stable(desc_addr_o));

    // R9
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_req_o && !buf_done_i |=> buf_req_o && $stable(buf_addr_o) && $stable(buf_len_o));

    // R3
    nonzero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_req_o |-> buf_len_o != '0);

    // R7
    frame_evt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> buf_req_o && buf_done_i && frame_end_i);

    // R5
    stop_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_req_o && buf_done_i && frame_end_i |=> !buf_req_o);

    // R8
    err_at_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        size_err_o |-> desc_req_o && desc_valid_i);

endmodule

bind rxdesc_seq rxdesc_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/rxdesc_seq_bench.sv
module rxdesc_seq_bench;

    localparam int AW = 32;
    localparam int SKIP_W = 5;
    localparam logic [AW-1:0] BASE = 32'h0000_8000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [AW-1:0]     list_base_i = BASE;
    logic [SKIP_W-1:0] skip_words_i = '0;
    logic              desc_req_o;
    logic [AW-1:0]     desc_addr_o;
    logic              desc_valid_i = 1'b0;
    logic [31:0]       desc_ctrl_i = '0;
    logic [AW-1:0]     desc_ptr1_i = '0;
    logic [AW-1:0]     desc_ptr2_i = '0;
    logic              buf_req_o;
    logic [AW-1:0]     buf_addr_o;
    logic [12:0]       buf_len_o;
    logic              buf_done_i = 1'b0;
    logic              frame_end_i = 1'b0;
    logic              frame_done_o;
    logic              size_err_o;

    int total = 0;
    int bad = 0;
    logic [AW-1:0] exp_cur;

    always #4 clk = ~clk;

    rxdesc_seq u_rxdesc_seq (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic serve(input int i);
        int s1i = i % 4;
        int s2i = (i / 4) % 3;
        bit chain = ((i / 12) % 2) == 1;
        bit eor = ((i / 24) % 2) == 1;
        bit dic = ((i / 48) % 2) == 1;
        int fe = (i / 96) % 3;
        bit rsv = ((i / 3) % 2) == 1;
        logic [12:0] sz1;
        logic [12:0] sz2;
        logic [AW-1:0] p1 = 32'h1000_0000 + 32'(i) * 32'h100;
        logic [AW-1:0] p2 = 32'h2000_0000 + 32'(i) * 32'h40;
        logic [SKIP_W-1:0] skip = SKIP_W'(i % 4);
        bit b1;
        bit b2;
        int nb;
        int fe_idx;
        bit err;
        sz1 = (s1i == 0) ? 13'd0 : (s1i == 1) ? 13'd8 : (s1i == 2) ? 13'd8188 : 13'd6;
        sz2 = (s2i == 0) ? 13'd0 : (s2i == 1) ? 13'd20 : 13'd18;
        b1 = sz1 != 0;
        b2 = !chain && sz2 != 0;
        nb = int'(b1) + int'(b2);
        fe_idx = (fe == 0 || nb == 0) ? -1 : (fe == 1) ? 0 : nb - 1;
        err = (sz1 % 4 != 0) || (b2 && (sz2 % 4 != 0));
        while (!desc_req_o) @(negedge clk);
        // R6 (R1 for the first descriptor)
        check(desc_addr_o == exp_cur, (i == 0) ? "R1 first fetch" : "R6 next address",
              64'(desc_addr_o), 64'(exp_cur));
        skip_words_i = skip;
        // R2: bit 31 quiet, 30:29 rsv, 28:16 len2, 15 ring end, 14 chain, 13 rsv, 12:0 len1
        desc_ctrl_i = {dic, {2{rsv}}, sz2, eor, chain, rsv, sz1};
        desc_ptr1_i = p1;
        desc_ptr2_i = p2;
        desc_valid_i = 1'b1;
        #1;
        check(size_err_o == err, "R8 size error", 64'(size_err_o), 64'(err));
        check(buf_req_o == 1'b0, "R9 no buffer during fetch", 64'(buf_req_o), 64'd0);
        @(negedge clk);
        desc_valid_i = 1'b0;
        desc_ctrl_i = '0;
        if (nb == 0)
            check(buf_req_o == 1'b0, "R3 empty buffers skipped", 64'(buf_req_o), 64'd0);
        for (int j = 0; j < nb; j++) begin
            bit first = b1 && (j == 0);
            bit fend = (j == fe_idx);
            check(buf_req_o == 1'b1, first ? "R3 request" : "R4 request", 64'(buf_req_o), 64'd1);
            check(buf_addr_o == (first ? p1 : p2), first ? "R3 address" : "R4 address",
                  64'(buf_addr_o), 64'(first ? p1 : p2));
            check(buf_len_o == (first ? sz1 : sz2), first ? "R3 length" : "R4 length",
                  64'(buf_len_o), 64'(first ? sz1 : sz2));
            buf_done_i = 1'b1;
            frame_end_i = fend;
            if (i % 5 == 0) begin
                list_base_i = 32'h0000_F000;   // R10: start while busy must be ignored
                start_i = 1'b1;
            end
            #1;
            check(frame_done_o == (fend && !dic), "R7 frame event", 64'(frame_done_o), 64'(fend && !dic));
            @(negedge clk);
            buf_done_i = 1'b0;
            frame_end_i = 1'b0;
            start_i = 1'b0;
            list_base_i = BASE;
            if (fend) begin
                check(buf_req_o == 1'b0, "R5 no buffer after frame end", 64'(buf_req_o), 64'd0);
                break;
            end
        end
        exp_cur = eor ? BASE : chain ? p2 : exp_cur + 32'd16 + 32'(skip) * 32'd4;
    endtask

    initial begin
        exp_cur = BASE;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(desc_req_o == 1'b0, "R1 idle no fetch", 64'(desc_req_o), 64'd0);
        check(buf_req_o == 1'b0, "R1 idle no buffer", 64'(buf_req_o), 64'd0);
        check(frame_done_o == 1'b0, "R1 idle no event", 64'(frame_done_o), 64'd0);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 288; i++) serve(i);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule